// File: doc/BRIEF.md
# Monochrome Framebuffer Line Streamer

The block moves a 1-bit-per-pixel picture from a framebuffer RAM to a serial panel framer, one row at a time. The default geometry is 64 rows of 16 bytes, 1024 bytes in all, with one byte per RAM address. An update trigger carries a dirty row range. The block widens that range to whole 16-row bands. For each row in the widened range it sends an address request and then a data request that carries the row's 16 bytes. Every byte has its bit order reversed, so the leftmost pixel lands in the bit position the panel expects. After each request the block holds off for a fixed wait time before it issues the next one.

Each reversed byte is also written to a shadow RAM through a write port, at the same index it came from. A clear trigger zeroes all 1024 shadow locations. It then sends one panel instruction with code 0x01 and waits a longer, fixed time. A done pulse marks the end of every accepted operation. Triggers that arrive while an operation is running are dropped.

The framebuffer RAM has one cycle of read latency. The 16 bytes of a row are read into a line register while the address request's wait runs, so the data request goes out with a complete line.

Top module: `fbls_streamer`

## Requirements
- R1: After reset, and until a trigger is accepted, req_valid, done, fb_rd_en and sh_we are all 0.
- R2: An accepted update covers rows lo to hi-1, in ascending order. lo is upd_first rounded down to a multiple of 16. hi is upd_end rounded up to a multiple of 16 and then limited to 64. When hi <= lo, the block sends no request, performs no read and pulses done once.
- R3: For each row the block sends an address request (req_kind = 1, req_row = row) and then a data request (req_kind = 2) for the same row. The request pair for one row ends before the pair for the next row starts.
- R4: In a data request, byte c of the row is carried in req_line[8c+7:8c]. That byte is the framebuffer byte at address row*16 + c with its bits reversed: output bit i is input bit 7-i.
- R5: During an update, each reversed byte is written to the shadow port (sh_we = 1) at address row*16 + c. Shadow addresses outside the covered rows are not written.
- R6: Consecutive request pulses (req_valid is high for one cycle per request) are at least WAIT_CYC clock cycles apart.
- R7: A clear writes 0 to all 1024 shadow addresses. It then sends one request with req_kind = 3 and req_cmd = 0x01. done follows that request no sooner than CLR_WAIT_CYC cycles later.
- R8: upd_go and clr_go pulses that arrive while an operation is running have no effect. They cause no extra request, no shadow write and no extra done.
- R9: done is a one-cycle pulse, given exactly once per accepted operation. For an update it comes at least WAIT_CYC cycles after the last data request.
- R10: When clr_go and upd_go are both high in the same idle cycle, only the clear is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_go | input | 1 | Update trigger pulse |
| upd_first | input | 6 | First dirty row |
| upd_end | input | 7 | Dirty range end row, exclusive |
| clr_go | input | 1 | Clear trigger pulse |
| fb_rd_en | output | 1 | Framebuffer read enable |
| fb_rd_addr | output | 10 | Framebuffer read address (row*16 + column) |
| fb_rd_data | input | 8 | Framebuffer read data, one cycle after the enable |
| sh_we | output | 1 | Shadow RAM write enable |
| sh_addr | output | 10 | Shadow RAM write address |
| sh_wdata | output | 8 | Shadow RAM write data |
| req_valid | output | 1 | One-cycle request pulse to the framer |
| req_kind | output | 2 | 1 = row address, 2 = line data, 3 = instruction |
| req_row | output | 6 | Row of an address or data request |
| req_line | output | 128 | Reversed line bytes, byte c in bits 8c+7:8c |
| req_cmd | output | 8 | Instruction code for kind 3 |
| done | output | 1 | Operation complete pulse |

## Verification
The bench builds the block with the default 64x16 geometry and 16-row bands. It shortens WAIT_CYC to 12 and CLR_WAIT_CYC to 60. Because a 12-cycle wait is shorter than the 18-cycle line prefetch, the gap between the address and data requests is set by the prefetch, while the gap after the data request is set by the timer, so both paths that gate the next request are exercised. Short waits also let full-frame updates, the end cap at 64, empty ranges, busy-time triggers and a complete 1024-byte clear all fit in one run, alongside randomly chosen ranges.

// File: rtl/fbls_pkg.sv
package fbls_pkg;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_ADDR = 2'd1,
    REQ_DATA = 2'd2,
    REQ_CMD  = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT_A,
    ST_DATA,
    ST_WAIT_D,
    ST_CLR_FILL,
    ST_CLR_CMD,
    ST_CLR_WAIT
  } seq_state_e;

  localparam logic [7:0] PANEL_CLEAR_CODE = 8'h01;

endpackage

// File: rtl/fbls_bitrev.sv
module fbls_bitrev #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar i = 0; i < W; i++) begin : g_swap
    assign dout[i] = din[W-1-i];
  end

endmodule

// File: rtl/fbls_wait_timer.sv
module fbls_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (load) begin
        cnt <= len;
      end else if (cnt != '0) begin
        cnt     <= cnt - 1'b1;
        expired <= (cnt == TW'(1));
      end
    end
  end

  // R6: a wait is never restarted while one is still running
  a_r6_no_reload: assert property (@(posedge clk) disable iff (rst)
    load |-> (cnt == '0));

endmodule

// File: rtl/fbls_line_fetch.sv
module fbls_line_fetch #(
  parameter int ROWS_LG = 6,
  parameter int BPR_LG  = 4,
  parameter int BYTE_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [ROWS_LG-1:0]           row,
  output logic                         rd_en,
  output logic [ROWS_LG+BPR_LG-1:0]    rd_addr,
  input  logic [BYTE_W-1:0]            rd_data,
  output logic                         wr_v,
  output logic [ROWS_LG+BPR_LG-1:0]    wr_addr,
  output logic [BYTE_W-1:0]            wr_data,
  output logic [(1<<BPR_LG)*BYTE_W-1:0] line,
  output logic                         fill_done
);

  localparam int BPR = 1 << BPR_LG;
  localparam int AW  = ROWS_LG + BPR_LG;

  logic [BPR_LG-1:0] col;
  logic              cap_v;
  logic [AW-1:0]     cap_addr;
  logic [BYTE_W-1:0] rev_byte;

  fbls_bitrev #(.W(BYTE_W)) u_rev (
    .din  (rd_data),
    .dout (rev_byte)
  );

  assign rd_addr = {row, col};
  assign wr_v    = cap_v;
  assign wr_addr = cap_addr;
  assign wr_data = rev_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en     <= 1'b0;
      col       <= '0;
      cap_v     <= 1'b0;
      cap_addr  <= '0;
      fill_done <= 1'b0;
      line      <= '0;
    end else begin
      fill_done <= 1'b0;
      cap_v     <= rd_en;
      cap_addr  <= rd_addr;
      if (start) begin
        rd_en <= 1'b1;
        col   <= '0;
      end else if (rd_en) begin
        if (col == BPR_LG'(BPR - 1)) rd_en <= 1'b0;
        else                         col   <= col + 1'b1;
      end
      if (cap_v) begin
        line[int'(cap_addr[BPR_LG-1:0])*BYTE_W +: BYTE_W] <= rev_byte;
        if (cap_addr[BPR_LG-1:0] == BPR_LG'(BPR - 1)) fill_done <= 1'b1;
      end
    end
  end

  // R4: a new line is never started while the previous one is in flight
  a_r4_no_restart: assert property (@(posedge clk) disable iff (rst)
    start |-> (!rd_en && !cap_v));

endmodule

// File: rtl/fbls_streamer.sv
module fbls_streamer
  import fbls_pkg::*;
#(
  parameter int ROWS_LG      = 6,
  parameter int BPR_LG       = 4,
  parameter int BAND_LG      = 4,
  parameter int BYTE_W       = 8,
  parameter int WAIT_CYC     = 9000,
  parameter int CLR_WAIT_CYC = 200000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          upd_go,
  input  logic [ROWS_LG-1:0]            upd_first,
  input  logic [ROWS_LG:0]              upd_end,
  input  logic                          clr_go,
  output logic                          fb_rd_en,
  output logic [ROWS_LG+BPR_LG-1:0]     fb_rd_addr,
  input  logic [BYTE_W-1:0]             fb_rd_data,
  output logic                          sh_we,
  output logic [ROWS_LG+BPR_LG-1:0]     sh_addr,
  output logic [BYTE_W-1:0]             sh_wdata,
  output logic                          req_valid,
  output logic [1:0]                    req_kind,
  output logic [ROWS_LG-1:0]            req_row,
  output logic [(1<<BPR_LG)*BYTE_W-1:0] req_line,
  output logic [7:0]                    req_cmd,
  output logic                          done
);

  localparam int ROWS   = 1 << ROWS_LG;
  localparam int BAND   = 1 << BAND_LG;
  localparam int AW     = ROWS_LG + BPR_LG;
  localparam int LINE_W = (1 << BPR_LG) * BYTE_W;
  localparam int TMAX   = (CLR_WAIT_CYC > WAIT_CYC) ? CLR_WAIT_CYC : WAIT_CYC;
  localparam int TW     = $clog2(TMAX + 1);
  localparam int SW     = ROWS_LG + 2;

  seq_state_e        state;
  logic [ROWS_LG:0]  row_q;
  logic [ROWS_LG:0]  end_q;
  logic [AW-1:0]     clr_addr;
  logic              t_seen;
  logic              f_seen;

  // dirty range widening
  logic [ROWS_LG:0]  lo_row;
  logic [ROWS_LG:0]  hi_row;
  logic [SW-1:0]     up_sum;
  logic [SW-1:0]     up_band;
  logic              rng_empty;

  always_comb begin
    lo_row    = ({1'b0, upd_first} >> BAND_LG) << BAND_LG;
    up_sum    = {1'b0, upd_end} + SW'(BAND - 1);
    up_band   = (up_sum >> BAND_LG) << BAND_LG;
    hi_row    = (up_band > SW'(ROWS)) ? (ROWS_LG+1)'(ROWS) : up_band[ROWS_LG:0];
    rng_empty = (hi_row <= lo_row);
  end

  // wait timer
  logic          tmr_load;
  logic [TW-1:0] tmr_len;
  logic          tmr_exp;

  assign tmr_load = (state == ST_ADDR) || (state == ST_DATA) || (state == ST_CLR_CMD);
  assign tmr_len  = (state == ST_CLR_CMD) ? TW'(CLR_WAIT_CYC) : TW'(WAIT_CYC);

  fbls_wait_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .len     (tmr_len),
    .expired (tmr_exp)
  );

  // line prefetch
  logic              fetch_start;
  logic              fw_v;
  logic [AW-1:0]     fw_addr;
  logic [BYTE_W-1:0] fw_data;
  logic [LINE_W-1:0] line;
  logic              fill_done;

  assign fetch_start = (state == ST_ADDR);

  fbls_line_fetch #(
    .ROWS_LG (ROWS_LG),
    .BPR_LG  (BPR_LG),
    .BYTE_W  (BYTE_W)
  ) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .start     (fetch_start),
    .row       (row_q[ROWS_LG-1:0]),
    .rd_en     (fb_rd_en),
    .rd_addr   (fb_rd_addr),
    .rd_data   (fb_rd_data),
    .wr_v      (fw_v),
    .wr_addr   (fw_addr),
    .wr_data   (fw_data),
    .line      (line),
    .fill_done (fill_done)
  );

  logic t_ok;
  logic f_ok;
  assign t_ok = tmr_exp || t_seen;
  assign f_ok = fill_done || f_seen;

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      row_q     <= '0;
      end_q     <= '0;
      clr_addr  <= '0;
      t_seen    <= 1'b0;
      f_seen    <= 1'b0;
      req_valid <= 1'b0;
      req_kind  <= REQ_NONE;
      req_row   <= '0;
      req_line  <= '0;
      req_cmd   <= '0;
      done      <= 1'b0;
      sh_we     <= 1'b0;
      sh_addr   <= '0;
      sh_wdata  <= '0;
    end else begin
      req_valid <= 1'b0;
      done      <= 1'b0;
      sh_we     <= 1'b0;
      if (fw_v) begin
        sh_we    <= 1'b1;
        sh_addr  <= fw_addr;
        sh_wdata <= fw_data;
      end
      unique case (state)
        ST_IDLE: begin
          if (clr_go) begin
            clr_addr <= '0;
            state    <= ST_CLR_FILL;
          end else if (upd_go) begin
            if (rng_empty) begin
              done <= 1'b1;
            end else begin
              row_q <= lo_row;
              end_q <= hi_row;
              state <= ST_ADDR;
            end
          end
        end
        ST_ADDR: begin
          req_valid <= 1'b1;
          req_kind  <= REQ_ADDR;
          req_row   <= row_q[ROWS_LG-1:0];
          t_seen    <= 1'b0;
          f_seen    <= 1'b0;
          state     <= ST_WAIT_A;
        end
        ST_WAIT_A: begin
          if (t_ok && f_ok) begin
            state <= ST_DATA;
          end else begin
            t_seen <= t_ok;
            f_seen <= f_ok;
          end
        end
        ST_DATA: begin
          req_valid <= 1'b1;
          req_kind  <= REQ_DATA;
          req_row   <= row_q[ROWS_LG-1:0];
          req_line  <= line;
          state     <= ST_WAIT_D;
        end
        ST_WAIT_D: begin
          if (tmr_exp) begin
            if (row_q + 1'b1 == end_q) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              row_q <= row_q + 1'b1;
              state <= ST_ADDR;
            end
          end
        end
        ST_CLR_FILL: begin
          sh_we    <= 1'b1;
          sh_addr  <= clr_addr;
          sh_wdata <= '0;
          clr_addr <= clr_addr + 1'b1;
          if (clr_addr == '1) state <= ST_CLR_CMD;
        end
        ST_CLR_CMD: begin
          req_valid <= 1'b1;
          req_kind  <= REQ_CMD;
          req_cmd   <= PANEL_CLEAR_CODE;
          state     <= ST_CLR_WAIT;
        end
        ST_CLR_WAIT: begin
          if (tmr_exp) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // checker state: cycles since the previous request and its kind and row
  logic [TW-1:0]      gap_cnt;
  logic [1:0]         prev_kind;
  logic [ROWS_LG-1:0] prev_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt   <= '1;
      prev_kind <= REQ_NONE;
      prev_row  <= '0;
    end else if (req_valid) begin
      gap_cnt   <= TW'(1);
      prev_kind <= req_kind;
      prev_row  <= req_row;
    end else if (gap_cnt != '1) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R6: requests keep the minimum spacing
  a_r6_spacing: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (gap_cnt >= TW'(WAIT_CYC)));

  // R3: a data request directly follows the address request of its row
  a_r3_pair_order: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == REQ_DATA) |-> (prev_kind == REQ_ADDR && prev_row == req_row));

  // R2: streamed rows stay below the widened end
  a_r2_row_bound: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind != REQ_CMD) |-> ({1'b0, req_row} < end_q));

  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: a trigger during a running operation leaves the range untouched
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (upd_go && state != ST_IDLE) |=> $stable(end_q));

endmodule

// File: tb/fbls_streamer_tb.sv
module fbls_streamer_tb;

  localparam int WAIT_CYC = 12;
  localparam int CLR_WAIT = 60;
  localparam int DEPTH    = 1024;

  logic         clk = 1'b0;
  logic         rst;
  logic         upd_go, clr_go;
  logic [5:0]   upd_first;
  logic [6:0]   upd_end;
  logic         fb_rd_en;
  logic [9:0]   fb_rd_addr;
  logic [7:0]   fb_rd_data;
  logic         sh_we;
  logic [9:0]   sh_addr;
  logic [7:0]   sh_wdata;
  logic         req_valid;
  logic [1:0]   req_kind;
  logic [5:0]   req_row;
  logic [127:0] req_line;
  logic [7:0]   req_cmd;
  logic         done;

  always #4 clk = ~clk;

  fbls_streamer #(.WAIT_CYC(WAIT_CYC), .CLR_WAIT_CYC(CLR_WAIT)) u_dut (
    .clk(clk), .rst(rst), .upd_go(upd_go), .upd_first(upd_first), .upd_end(upd_end),
    .clr_go(clr_go), .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr), .fb_rd_data(fb_rd_data),
    .sh_we(sh_we), .sh_addr(sh_addr), .sh_wdata(sh_wdata), .req_valid(req_valid),
    .req_kind(req_kind), .req_row(req_row), .req_line(req_line), .req_cmd(req_cmd),
    .done(done)
  );

  logic [7:0] fb_mem [DEPTH];
  logic [7:0] sh_mem [DEPTH];
  logic [7:0] sh_snap [DEPTH];

  always @(posedge clk) if (fb_rd_en) fb_rd_data <= fb_mem[fb_rd_addr];

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  int n_req, n_done, n_rd;
  int done_cyc;
  logic [1:0]   r_kind [256];
  logic [5:0]   r_row  [256];
  logic [127:0] r_line [256];
  logic [7:0]   r_cmd  [256];
  int           r_cyc  [256];

  always @(negedge clk) begin
    cyc++;
    if (sh_we) sh_mem[sh_addr] = sh_wdata;
    if (fb_rd_en) n_rd++;
    if (done) begin n_done++; done_cyc = cyc; end
    if (req_valid && n_req < 256) begin
      r_kind[n_req] = req_kind; r_row[n_req] = req_row;
      r_line[n_req] = req_line; r_cmd[n_req] = req_cmd; r_cyc[n_req] = cyc;
      n_req++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction

  function automatic int lo_of(input int f);
    return (f / 16) * 16;
  endfunction

  function automatic int hi_of(input int e);
    int h = ((e + 15) / 16) * 16;
    return (h > 64) ? 64 : h;
  endfunction

  task automatic clear_rec();
    n_req = 0; n_done = 0; n_rd = 0; done_cyc = 0;
    for (int i = 0; i < DEPTH; i++) sh_snap[i] = sh_mem[i];
  endtask

  task automatic wait_done();
    int t = 0;
    while (n_done == 0 && t < 20000) begin @(negedge clk); t++; end
    repeat (80) @(negedge clk);
  endtask

  task automatic fill_fb();
    for (int i = 0; i < DEPTH; i++) fb_mem[i] = 8'($urandom);
  endtask

  task automatic run_update(input int f, input int e, input bit busy_poke);
    int lo, hi, nrows, bad_ln, bad_sh;
    logic [127:0] exp_ln;
    lo = lo_of(f); hi = hi_of(e);
    nrows = (hi > lo) ? hi - lo : 0;
    clear_rec();
    @(negedge clk);
    upd_go = 1'b1; upd_first = 6'(f); upd_end = 7'(e);
    @(negedge clk);
    upd_go = 1'b0;
    if (busy_poke && nrows > 0) begin
      repeat (5) @(negedge clk);
      upd_go = 1'b1; clr_go = 1'b1; upd_first = 6'((f + 17) % 64); upd_end = 7'(64);
      @(negedge clk);
      upd_go = 1'b0; clr_go = 1'b0;
    end
    wait_done();
    // R2 count of requests and R9 single done
    chk(n_req == 2 * nrows, "R2 request count", n_req, 2 * nrows);
    chk(n_done == 1, "R9 done count", n_done, 1);
    if (nrows == 0) chk(n_rd == 0, "R2 empty range reads", n_rd, 0);
    bad_ln = 0;
    for (int k = 0; k < n_req && k < 2 * nrows; k++) begin
      int row = lo + k / 2;
      if (k % 2 == 0) begin
        chk(r_kind[k] == 2'd1 && r_row[k] == 6'(row), "R3 address request", {r_kind[k], r_row[k]}, {2'd1, 6'(row)});
      end else begin
        for (int c = 0; c < 16; c++) exp_ln[8*c +: 8] = rev8(fb_mem[row*16 + c]);
        chk(r_kind[k] == 2'd2 && r_row[k] == 6'(row), "R3 data request", {r_kind[k], r_row[k]}, {2'd2, 6'(row)});
        if (r_line[k] != exp_ln) begin
          bad_ln++;
          chk(1'b0, "R4 line payload", r_line[k][63:0], exp_ln[63:0]);
        end
      end
      if (k > 0) chk(r_cyc[k] - r_cyc[k-1] >= WAIT_CYC, "R6 request spacing", r_cyc[k] - r_cyc[k-1], WAIT_CYC);
    end
    chk(bad_ln == 0, "R4 lines", bad_ln, 0);
    if (nrows > 0) chk(done_cyc - r_cyc[n_req-1] >= WAIT_CYC, "R9 done after final wait", done_cyc - r_cyc[n_req-1], WAIT_CYC);
    bad_sh = 0;
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] ev;
      ev = (a / 16 >= lo && a / 16 < hi) ? rev8(fb_mem[a]) : sh_snap[a];
      if (sh_mem[a] != ev) begin
        if (bad_sh == 0) chk(1'b0, busy_poke ? "R8 shadow after busy trigger" : "R5 shadow byte", sh_mem[a], ev);
        bad_sh++;
      end
    end
    chk(bad_sh == 0, "R5 shadow contents", bad_sh, 0);
  endtask

  task automatic run_clear(input bit with_upd, input bit busy_poke);
    int bad_sh;
    clear_rec();
    @(negedge clk);
    clr_go = 1'b1; upd_go = with_upd; upd_first = 6'd0; upd_end = 7'd64;
    @(negedge clk);
    clr_go = 1'b0; upd_go = 1'b0;
    if (busy_poke) begin
      repeat (300) @(negedge clk);
      upd_go = 1'b1; upd_first = 6'd0; upd_end = 7'd20;
      @(negedge clk);
      upd_go = 1'b0;
    end
    wait_done();
    bad_sh = 0;
    for (int a = 0; a < DEPTH; a++) if (sh_mem[a] != 8'h00) bad_sh++;
    chk(bad_sh == 0, "R7 shadow zeroed", bad_sh, 0);
    chk(n_req == 1, with_upd ? "R10 clear wins, single request" : "R7 single request", n_req, 1);
    chk(r_kind[0] == 2'd3 && r_cmd[0] == 8'h01, "R7 instruction code", {r_kind[0], r_cmd[0]}, {2'd3, 8'h01});
    chk(n_done == 1, busy_poke ? "R8 done count during clear" : "R9 done count", n_done, 1);
    chk(done_cyc - r_cyc[0] >= CLR_WAIT, "R7 clear wait", done_cyc - r_cyc[0], CLR_WAIT);
    chk(n_rd == 0, "R10 no framebuffer reads", n_rd, 0);
  endtask

  initial begin
    process::self().srandom(32'd7321);
    rst = 1'b1; upd_go = 1'b0; clr_go = 1'b0; upd_first = '0; upd_end = '0;
    n_req = 0; n_done = 0; n_rd = 0; done_cyc = 0;
    for (int i = 0; i < DEPTH; i++) sh_mem[i] = 8'h00;
    fill_fb();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_valid == 0 && done == 0 && fb_rd_en == 0 && sh_we == 0, "R1 reset outputs",
        {req_valid, done, fb_rd_en, sh_we}, 0);

    run_update(0, 64, 1'b0);           // full frame
    fill_fb();
    run_update(20, 21, 1'b0);          // widened to 16..31
    run_update(5, 70, 1'b0);           // end capped at 64
    run_update(50, 10, 1'b0);          // empty after widening
    run_update(0, 0, 1'b0);            // empty
    run_update(16, 32, 1'b0);          // exact band
    fill_fb();
    run_update(33, 40, 1'b1);          // R8 triggers while busy
    run_clear(1'b1, 1'b0);             // R10 simultaneous triggers
    run_update(48, 64, 1'b0);
    run_clear(1'b0, 1'b1);             // R8 trigger during clear
    for (int t = 0; t < 8; t++) begin
      int f = $urandom_range(63);
      int e = $urandom_range(80);
      fill_fb();
      run_update(f, e, 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule